// File: doc/BRIEF.md
# Software Flow-Control Character Filter and Transmit Pause

This block sits between a UART receiver and its receive FIFO, and beside the transmitter. Each received byte is compared with programmed resume and pause characters. A byte that matches is taken out of the data stream. A pause match stops the transmitter, and a resume match lets it run again. All other bytes go on to the FIFO write port one cycle later. The transmitter is never stopped in the middle of a character. A pause that arrives while a character is shifting out takes effect only once that character's done strobe has been seen.

Four 8-bit character registers are loaded through a small write port. In single mode one byte forms a control code. In pair mode a control code is two consecutive bytes: pause-first followed by pause-second, or resume-first followed by resume-second. A pair-mode first byte is held back until the next byte shows whether the pair is complete. If the pair is not completed, the held byte is released to the FIFO ahead of the byte that broke the pair. An interrupt status flag records a pause match when enabled, and a resume match clears it.

Top module: `xonxoff_gate`

## Requirements
- R1: Reset clears all four character registers to 0x00. A write with `cfg_we` high stores `cfg_wdata` in the register chosen by `cfg_sel`, which uses the encoding 0 = resume-first, 1 = resume-second, 2 = pause-first, 3 = pause-second.
- R2: In single mode (`dbl_mode`=0), a byte equal to pause-first is a pause match and a byte equal to resume-first is a resume match. When both registers hold the same value, the pause match wins.
- R3: On a pause match, if `tx_busy` is low in the cycle after the byte was accepted, `tx_allow` falls one cycle later. If a character is in flight, `tx_allow` stays high until the cycle after `tx_done` pulses.
- R4: A pause match sets `irq` only when `irq_en` is high. With `irq_en` low, `irq` stays low.
- R5: A resume match clears `irq` and sets `tx_allow` high again, which also cancels a pending halt. A resume match while the transmitter is already running changes nothing.
- R6: Bytes that form a control code never appear on the FIFO write port. Every other byte appears with `fifo_we` high exactly once, in arrival order, one cycle after it was accepted unless it was held.
- R7: In pair mode (`dbl_mode`=1), pause-first followed directly by pause-second is a pause match, and resume-first followed by resume-second is a resume match.
- R8: In pair mode, a held first byte that is followed by a byte not completing its pair is written on the next cycle. A new byte that does not start a pair is then written on the cycle after that.
- R9: In pair mode, a byte that starts a pair arriving while another first byte is held causes the older byte to be written. The newer byte then becomes the held one.
- R10: With `sw_en` low no matching takes place. Every byte, including control values, is written to the FIFO, and neither `tx_allow` nor `irq` changes.
- R11: `rx_vld` is never high on two consecutive cycles. The receiver's byte rate guarantees this.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Character register write strobe |
| cfg_sel | input | 2 | Register select (see R1) |
| cfg_wdata | input | 8 | Character value to write |
| sw_en | input | 1 | Software flow control enable |
| dbl_mode | input | 1 | 1 = two-character codes, 0 = single |
| irq_en | input | 1 | Allow a pause match to raise `irq` |
| rx_vld | input | 1 | Received byte valid strobe |
| rx_data | input | 8 | Received byte |
| tx_busy | input | 1 | Transmitter is shifting a character |
| tx_done | input | 1 | Transmitter finished a character |
| fifo_we | output | 1 | Receive FIFO write enable |
| fifo_data | output | 8 | Byte written to the receive FIFO |
| tx_allow | output | 1 | Transmitter may start a new character |
| irq | output | 1 | Flow-control interrupt status |

## Verification
Two functions can meet in the same cycle: the internal pause event and the transmitter's character-done strobe. The bench times `tx_done` to land in exactly the cycle the pause event is registered, and expects `tx_allow` to fall right after that edge. It repeats the run with `tx_done` one cycle too early and expects the halt to wait for a later strobe. The FIFO scoreboard judges the second contention, between a released held byte and the byte that follows it. It requires the two writes on back-to-back cycles in order.

// File: rtl/xg_pkg.sv
package xg_pkg;
  localparam int CHR_W = 8;
  localparam int N_CHR = 4;

  typedef enum logic [1:0] {
    SEL_ON1  = 2'd0,
    SEL_ON2  = 2'd1,
    SEL_OFF1 = 2'd2,
    SEL_OFF2 = 2'd3
  } chr_sel_e;

  // A comparison counts only while matching is enabled
  function automatic logic chr_hit(input logic en, input logic [CHR_W-1:0] a,
                                   input logic [CHR_W-1:0] b);
    return en && (a == b);
  endfunction

  // The transmitter may be stopped when idle or as its character ends
  function automatic logic at_boundary(input logic busy, input logic done);
    return !busy || done;
  endfunction
endpackage

// File: rtl/xg_char_regs.sv
module xg_char_regs #(
  parameter int W = xg_pkg::CHR_W,
  parameter int N = xg_pkg::N_CHR,
  localparam int SW = $clog2(N)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [SW-1:0]       wr_sel,
  input  logic [W-1:0]        wr_data,
  output logic [N-1:0][W-1:0] chars
);
  for (genvar i = 0; i < N; i++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               chars[i] <= '0;
      else if (wr_en && wr_sel == SW'(i))       chars[i] <= wr_data;
    end
  end

  // R1: a written register holds the written value on the next cycle
  p_reg_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> chars[$past(wr_sel)] == $past(wr_data));
endmodule

// File: rtl/xg_matcher.sv
module xg_matcher
  import xg_pkg::*;
#(
  parameter int W = CHR_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sw_en,
  input  logic                    dbl_mode,
  input  logic                    rx_vld,
  input  logic [W-1:0]            rx_data,
  input  logic [N_CHR-1:0][W-1:0] chars,
  output logic                    fifo_we,
  output logic [W-1:0]            fifo_data,
  output logic                    ev_xoff,
  output logic                    ev_xon
);
  logic         pend_vld, pend_off;
  logic [W-1:0] pend_data;
  logic         stash_vld;
  logic [W-1:0] stash_data;

  logic         n_we, n_pend_vld, n_pend_off, n_stash_vld, n_off, n_on;
  logic [W-1:0] n_data, n_pend_data, n_stash_data;

  logic hit_off1, hit_on1, hit_off2, hit_on2;
  logic pair_done, starter, single_hit;

  always_comb begin
    hit_off1   = chr_hit(sw_en, rx_data, chars[SEL_OFF1]);
    hit_on1    = chr_hit(sw_en, rx_data, chars[SEL_ON1]) && !hit_off1;
    hit_off2   = chr_hit(sw_en, rx_data, chars[SEL_OFF2]);
    hit_on2    = chr_hit(sw_en, rx_data, chars[SEL_ON2]);
    pair_done  = pend_vld && (pend_off ? hit_off2 : hit_on2);
    starter    = dbl_mode && (hit_off1 || hit_on1);
    single_hit = !dbl_mode && (hit_off1 || hit_on1);
  end

  always_comb begin
    n_we         = 1'b0;
    n_data       = fifo_data;
    n_pend_vld   = pend_vld;
    n_pend_off   = pend_off;
    n_pend_data  = pend_data;
    n_stash_vld  = 1'b0;
    n_stash_data = stash_data;
    n_off        = 1'b0;
    n_on         = 1'b0;
    if (stash_vld) begin
      n_we   = 1'b1;
      n_data = stash_data;
    end
    if (rx_vld) begin
      if (pair_done) begin
        n_off      = pend_off;
        n_on       = !pend_off;
        n_pend_vld = 1'b0;
      end else begin
        if (pend_vld) begin
          n_we       = 1'b1;
          n_data     = pend_data;
          n_pend_vld = 1'b0;
        end
        if (starter) begin
          n_pend_vld  = 1'b1;
          n_pend_off  = hit_off1;
          n_pend_data = rx_data;
        end else if (single_hit) begin
          n_off = hit_off1;
          n_on  = hit_on1;
        end else if (pend_vld) begin
          n_stash_vld  = 1'b1;
          n_stash_data = rx_data;
        end else begin
          n_we   = 1'b1;
          n_data = rx_data;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fifo_we    <= 1'b0;
      fifo_data  <= '0;
      pend_vld   <= 1'b0;
      pend_off   <= 1'b0;
      pend_data  <= '0;
      stash_vld  <= 1'b0;
      stash_data <= '0;
      ev_xoff    <= 1'b0;
      ev_xon     <= 1'b0;
    end else begin
      fifo_we    <= n_we;
      fifo_data  <= n_data;
      pend_vld   <= n_pend_vld;
      pend_off   <= n_pend_off;
      pend_data  <= n_pend_data;
      stash_vld  <= n_stash_vld;
      stash_data <= n_stash_data;
      ev_xoff    <= n_off;
      ev_xon     <= n_on;
    end
  end

  // R11: received bytes are at least two cycles apart
  p_rx_gap_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rx_vld |=> !rx_vld);
  // R6: a cycle that reports a control code writes nothing
  p_flow_kept_out_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_xoff || ev_xon) |-> !fifo_we);
  // R8: a stashed byte follows the released held byte on the next cycle
  p_stash_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stash_vld |-> fifo_we ##1 (fifo_we && fifo_data == $past(stash_data)));
  // R10: with matching off and nothing held, a byte passes straight through
  p_disabled_pass_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_vld && !sw_en && !pend_vld) |=> (fifo_we && fifo_data == $past(rx_data)));
  // R7: only one kind of control event per cycle
  p_one_event_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_xoff, ev_xon}));
endmodule

// File: rtl/xg_txgate.sv
module xg_txgate
  import xg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ev_xoff,
  input  logic ev_xon,
  input  logic tx_busy,
  input  logic tx_done,
  input  logic irq_en,
  output logic tx_allow,
  output logic irq_flag
);
  logic susp, halt_pend;
  logic edge_ok;

  assign edge_ok  = at_boundary(tx_busy, tx_done);
  assign tx_allow = !susp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      susp      <= 1'b0;
      halt_pend <= 1'b0;
      irq_flag  <= 1'b0;
    end else if (ev_xon) begin
      susp      <= 1'b0;
      halt_pend <= 1'b0;
      irq_flag  <= 1'b0;
    end else begin
      if (ev_xoff && irq_en) irq_flag <= 1'b1;
      if (ev_xoff || halt_pend) begin
        if (edge_ok) begin
          susp      <= 1'b1;
          halt_pend <= 1'b0;
        end else begin
          halt_pend <= 1'b1;
        end
      end
    end
  end

  // R3: the transmitter is stopped only at a character boundary
  p_halt_boundary_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_allow) |-> (!$past(tx_busy) || $past(tx_done)));
  // R4: the status flag rises only from an enabled pause event
  p_irq_needs_en_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_flag) |-> ($past(ev_xoff) && $past(irq_en)));
  // R5: a resume event releases the transmitter and clears the flag
  p_resume_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_xon |=> (tx_allow && !irq_flag));
endmodule

// File: rtl/xonxoff_gate.sv
module xonxoff_gate
  import xg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic [1:0] cfg_sel,
  input  logic [7:0] cfg_wdata,
  input  logic       sw_en,
  input  logic       dbl_mode,
  input  logic       irq_en,
  input  logic       rx_vld,
  input  logic [7:0] rx_data,
  input  logic       tx_busy,
  input  logic       tx_done,
  output logic       fifo_we,
  output logic [7:0] fifo_data,
  output logic       tx_allow,
  output logic       irq
);
  logic [N_CHR-1:0][CHR_W-1:0] chars;
  logic ev_xoff, ev_xon;

  xg_char_regs #(.W(CHR_W), .N(N_CHR)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .wr_sel(cfg_sel),
    .wr_data(cfg_wdata), .chars(chars)
  );

  xg_matcher #(.W(CHR_W)) u_match (
    .clk(clk), .rst_n(rst_n), .sw_en(sw_en), .dbl_mode(dbl_mode),
    .rx_vld(rx_vld), .rx_data(rx_data), .chars(chars),
    .fifo_we(fifo_we), .fifo_data(fifo_data),
    .ev_xoff(ev_xoff), .ev_xon(ev_xon)
  );

  xg_txgate u_gate (
    .clk(clk), .rst_n(rst_n), .ev_xoff(ev_xoff), .ev_xon(ev_xon),
    .tx_busy(tx_busy), .tx_done(tx_done), .irq_en(irq_en),
    .tx_allow(tx_allow), .irq_flag(irq)
  );

  // R10: with matching off no control event is raised
  p_no_event_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_en && !$past(sw_en)) |-> !(ev_xoff || ev_xon));
endmodule

// File: tb/sim_xonxoff_gate.sv
`timescale 1ns/1ps
module sim_xonxoff_gate;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 0; logic [1:0] cfg_sel = 0; logic [7:0] cfg_wdata = 0;
  logic sw_en = 0, dbl_mode = 0, irq_en = 0, rx_vld = 0;
  logic [7:0] rx_data = 0;
  logic tx_busy = 0, tx_done = 0;
  logic fifo_we; logic [7:0] fifo_data; logic tx_allow, irq;

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2 clk = ~clk;

  xonxoff_gate u0 (.*);

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic expect_byte(input logic [7:0] b, input string tag);
    exp_q.push_back(b);
    tag_q.push_back(tag);
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk); rx_vld = 1; rx_data = b;
    @(negedge clk); rx_vld = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic wr_chr(input logic [1:0] sel, input logic [7:0] v);
    @(negedge clk); cfg_we = 1; cfg_sel = sel; cfg_wdata = v;
    @(negedge clk); cfg_we = 0;
  endtask

  // Scoreboard monitor: every FIFO write must match the queue head (R6)
  always @(negedge clk) begin
    if (rst_n && fifo_we === 1'b1) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R6 unexpected write actual=%0h expected=none", fifo_data);
      end else begin
        logic [7:0] e; string t;
        e = exp_q.pop_front(); t = tag_q.pop_front();
        if (fifo_data !== e) begin
          errors++;
          $display("FAIL %s fifo actual=%0h expected=%0h", t, fifo_data, e);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(fifo_we, 0, "reset fifo_we");
    chk(tx_allow, 1, "reset tx_allow");
    chk(irq, 0, "reset irq");

    // R1: registers reset to zero, so byte 0x00 is a pause match
    sw_en = 1; irq_en = 1; dbl_mode = 0;
    send(8'h00);
    chk(tx_allow, 0, "R1 zero char pauses");
    chk(irq, 1, "R4 irq set");

    wr_chr(2'd0, 8'h11); wr_chr(2'd1, 8'h12);
    wr_chr(2'd2, 8'h13); wr_chr(2'd3, 8'h14);
    send(8'h11);
    chk(tx_allow, 1, "R5 resume");
    chk(irq, 0, "R5 irq clear");

    // R2 / R6 data passes, control consumed
    expect_byte(8'h41, "R6 data");
    send(8'h41);
    send(8'h13);
    chk(tx_allow, 0, "R2 single pause");
    send(8'h11);
    chk(tx_allow, 1, "R2 single resume");
    send(8'h11);
    chk(tx_allow, 1, "R5 resume while running");

    // R10 matching disabled
    sw_en = 0;
    expect_byte(8'h13, "R10 pass 13");
    send(8'h13);
    chk(tx_allow, 1, "R10 no pause");
    chk(irq, 0, "R10 no irq");
    sw_en = 1;

    // R3 halt waits for character end
    tx_busy = 1;
    send(8'h13);
    chk(tx_allow, 1, "R3 still sending");
    @(negedge clk); tx_done = 1;
    @(negedge clk); tx_done = 0; tx_busy = 0;
    chk(tx_allow, 0, "R3 halt after done");
    send(8'h11);

    // R4 interrupt disabled
    irq_en = 0;
    send(8'h13);
    chk(tx_allow, 0, "R4 paused without irq");
    chk(irq, 0, "R4 irq masked");
    send(8'h11);
    irq_en = 1;

    // Coincidence: done strobe in the event cycle
    tx_busy = 1;
    @(negedge clk); rx_vld = 1; rx_data = 8'h13;
    @(negedge clk); rx_vld = 0; tx_done = 1;
    @(negedge clk); tx_done = 0; tx_busy = 0;
    chk(tx_allow, 0, "R3 done same cycle as event");
    send(8'h11);
    // done one cycle early must not count
    tx_busy = 1;
    @(negedge clk); rx_vld = 1; rx_data = 8'h13; tx_done = 1;
    @(negedge clk); rx_vld = 0; tx_done = 0;
    repeat (3) @(negedge clk);
    chk(tx_allow, 1, "R3 early done ignored");
    @(negedge clk); tx_done = 1;
    @(negedge clk); tx_done = 0; tx_busy = 0;
    chk(tx_allow, 0, "R3 later done halts");
    send(8'h11);

    // R7 pair mode
    dbl_mode = 1;
    send(8'h13); send(8'h14);
    chk(tx_allow, 0, "R7 pair pause");
    send(8'h11); send(8'h12);
    chk(tx_allow, 1, "R7 pair resume");

    // R8 broken pair
    send(8'h13);
    expect_byte(8'h13, "R8 held byte"); expect_byte(8'h55, "R8 breaker");
    send(8'h55);
    chk(tx_allow, 1, "R8 no pause");

    // R9 repeated first byte
    send(8'h13);
    expect_byte(8'h13, "R9 older held");
    send(8'h13); send(8'h14);
    chk(tx_allow, 0, "R9 newer completes pair");
    send(8'h11); send(8'h12);

    // R9 pause-first then resume pair
    send(8'h13);
    expect_byte(8'h13, "R9 held before resume");
    send(8'h11); send(8'h12);
    chk(tx_allow, 1, "R5 pair resume while running");

    repeat (4) @(negedge clk);
    chk(exp_q.size(), 0, "R6 all bytes written");
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule